// File: doc/BRIEF.md
# Two-Rail Carry Completion Adder

This block adds two unsigned operands and a carry-in, holding each internal carry in a two-rail code that can also say "not yet known". It is a clocked model of a self-timed adder: each clock cycle stands for one gate delay. In every cycle each carry may move forward by one bit position. A stage whose operand bits agree fixes its outgoing carry at once. A stage whose operand bits differ passes on whatever its incoming carry held in the previous cycle.

A global completion signal is the AND over all stages of "this carry is known". It ends the addition as soon as the longest propagate chain has resolved, so the latency depends on the data. The block reports the sum, the carry-out, a done flag and the number of settle cycles the addition took.

A caller pulses `start` with the operands while the block is idle. It then waits for `done` and reads `sum`, `cout` and `settle_cycles`, which stay valid until the next accepted start.

Top module: `dualrail_adder`

## Requirements
- R1: Each carry is a two-rail pair (zero rail, one rail): 00 means unknown, 01 means known 1, 10 means known 0. The pair 11 never occurs.
- R2: A `start` pulse while idle latches `a_in`, `b_in` and `cin` and sets every carry to unknown. On the following cycle `busy` is 1, `done` is 0 and `settle_cycles` is 0.
- R3: In each settle cycle the carry into bit 0 takes the injected value (NOT cin, cin). A stage with both operand bits 1 drives a known 1 upward, and both bits 0 drives a known 0. A stage with differing bits copies the state its incoming carry had in the previous cycle.
- R4: The addition is complete only when every carry is known, from the one into bit 0 up to and including the carry-out.
- R5: `settle_cycles` equals one plus the length of the longest run of adjacent bit positions where `a_in` and `b_in` differ. With no such position it is 1.
- R6: `done` rises and `busy` falls exactly L+2 clock edges after the start edge, where L is that longest run. At that point `{cout, sum}` equals `a_in + b_in + cin`.
- R7: A `start` pulse while `busy` is 1 is ignored. The running addition completes with its original operands and cycle count.
- R8: After reset, `busy`, `done`, `sum`, `cout` and `settle_cycles` are all 0.
- R9: The results and `done` stay unchanged while idle, until the next accepted start clears `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one edge models one gate delay |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an addition (only accepted while idle) |
| a_in | input | WIDTH | First operand |
| b_in | input | WIDTH | Second operand |
| cin | input | 1 | Carry into the least significant bit |
| busy | output | 1 | Carries are still settling |
| done | output | 1 | Results are valid |
| sum | output | WIDTH | Sum bits |
| cout | output | 1 | Carry out of the most significant bit |
| settle_cycles | output | $clog2(WIDTH+2) | Settle cycles used by the last addition |

## Verification
For every operand pair and carry-in of a 6-bit instance, the bench computes the longest differing-bit run L. It expects `done` on exactly the (L+2)th clock edge after the start edge, with `settle_cycles` equal to L+1. It drives inputs and samples outputs on falling edges, so each count of edges is exact. `busy` and a cleared counter are checked one edge after start. Held results are checked several idle edges after `done`. A second start is issued one edge into a full-length chain, and the bench confirms that the original answer and latency come back.

// File: rtl/drc_pkg.sv
package drc_pkg;
   typedef struct packed {
      logic zero;
      logic one;
   } rail_t;

   localparam rail_t RAIL_UNKNOWN = '{zero: 1'b0, one: 1'b0};

   function automatic rail_t rail_of(input logic value);
      return '{zero: ~value, one: value};
   endfunction
endpackage

// File: rtl/drc_stage.sv
module drc_stage
   import drc_pkg::*;
(
   input  logic  a_bit,
   input  logic  b_bit,
   input  rail_t carry_below,
   output rail_t carry_next
);
   logic generate_w;
   logic kill_w;

   assign generate_w = a_bit & b_bit;
   assign kill_w     = ~a_bit & ~b_bit;

   always_comb begin
      if (generate_w)   carry_next = rail_of(1'b1);
      else if (kill_w)  carry_next = rail_of(1'b0);
      else              carry_next = carry_below;
   end
endmodule

// File: rtl/drc_detect.sv
module drc_detect
   import drc_pkg::*;
#(
   parameter int N = 17
) (
   input  rail_t [N-1:0] rails,
   output logic          all_known
);
   logic [N-1:0] local_known;

   for (genvar i = 0; i < N; i++) begin : g_local
      assign local_known[i] = rails[i].zero | rails[i].one;
   end

   assign all_known = &local_known;
endmodule

// File: rtl/drc_counter.sv
module drc_counter #(
   parameter int CW = 5
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clear,
   input  logic          inc,
   output logic [CW-1:0] count
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      count <= '0;
      else if (clear)  count <= '0;
      else if (inc)    count <= count + 1'b1;
   end
endmodule

// File: rtl/dualrail_adder.sv
module dualrail_adder
   import drc_pkg::*;
#(
   parameter int WIDTH = 16,
   localparam int CW = $clog2(WIDTH + 2)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [WIDTH-1:0] a_in,
   input  logic [WIDTH-1:0] b_in,
   input  logic             cin,
   output logic             busy,
   output logic             done,
   output logic [WIDTH-1:0] sum,
   output logic             cout,
   output logic [CW-1:0]    settle_cycles
);
   localparam int RAILS = WIDTH + 1;

   if (WIDTH < 2) begin : g_bad_width
      $error("dualrail_adder: WIDTH must be at least 2");
   end

   logic [WIDTH-1:0]   a_q, b_q, sum_q, sum_w;
   logic               cin_q, running, done_q, cout_q, all_known, accept;
   rail_t [WIDTH:0]    carry_q, carry_d;

   assign accept     = start & ~running;
   assign carry_d[0] = rail_of(cin_q);

   for (genvar i = 0; i < WIDTH; i++) begin : g_stage
      drc_stage u_stage (
         .a_bit       (a_q[i]),
         .b_bit       (b_q[i]),
         .carry_below (carry_q[i]),
         .carry_next  (carry_d[i+1])
      );
      assign sum_w[i] = a_q[i] ^ b_q[i] ^ carry_q[i].one;
   end

   drc_detect #(.N(RAILS)) u_detect (
      .rails     (carry_q),
      .all_known (all_known)
   );

   drc_counter #(.CW(CW)) u_count (
      .clk   (clk),
      .rst_n (rst_n),
      .clear (accept),
      .inc   (running & ~all_known),
      .count (settle_cycles)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         a_q     <= '0;
         b_q     <= '0;
         cin_q   <= 1'b0;
         carry_q <= '0;
         running <= 1'b0;
         done_q  <= 1'b0;
         sum_q   <= '0;
         cout_q  <= 1'b0;
      end else if (accept) begin
         a_q     <= a_in;
         b_q     <= b_in;
         cin_q   <= cin;
         carry_q <= {RAILS{RAIL_UNKNOWN}};
         running <= 1'b1;
         done_q  <= 1'b0;
      end else if (running) begin
         if (all_known) begin
            running <= 1'b0;
            done_q  <= 1'b1;
            sum_q   <= sum_w;
            cout_q  <= carry_q[WIDTH].one;
         end else begin
            carry_q <= carry_d;
         end
      end
   end

   assign busy = running;
   assign done = done_q;
   assign sum  = sum_q;
   assign cout = cout_q;

   for (genvar j = 0; j < RAILS; j++) begin : g_chk
      assert_rail_legal_R1: assert property (@(posedge clk) disable iff (!rst_n)
         !(carry_q[j].zero && carry_q[j].one));
      assert_known_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
         (running && (carry_q[j].zero || carry_q[j].one)) |=> $stable(carry_q[j]));
   end

   assert_start_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> (running && !done_q && settle_cycles == '0));
   assert_done_needs_all_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done_q) |-> $past(all_known));
   assert_cycle_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
      settle_cycles <= CW'(WIDTH + 1));
   assert_sum_right_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done_q) |-> ({cout_q, sum_q} == ({1'b0, a_q} + {1'b0, b_q} + (WIDTH+1)'(cin_q))));
   assert_ignore_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (running && start) |=> ($stable(a_q) && $stable(b_q) && $stable(cin_q)));
   assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!running && !start && done_q) |=> ($stable(sum_q) && $stable(cout_q) && done_q));
endmodule

// File: tb/dualrail_adder_test.sv
module dualrail_adder_test;
   localparam int W  = 6;
   localparam int CW = $clog2(W + 2);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic [W-1:0] a_in = '0, b_in = '0;
   logic cin = 1'b0;
   logic busy, done, cout;
   logic [W-1:0] sum;
   logic [CW-1:0] settle_cycles;

   int tests = 0;
   int fails = 0;

   always #4 clk = ~clk;

   dualrail_adder #(.WIDTH(W)) uut (
      .clk(clk), .rst_n(rst_n), .start(start), .a_in(a_in), .b_in(b_in),
      .cin(cin), .busy(busy), .done(done), .sum(sum), .cout(cout),
      .settle_cycles(settle_cycles)
   );

   task automatic check(input string req, input longint act, input longint exp);
      tests++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int longest_run(input logic [W-1:0] a, input logic [W-1:0] b);
      int best = 0;
      int cur = 0;
      for (int i = 0; i < W; i++) begin
         if (a[i] ^ b[i]) begin
            cur++;
            if (cur > best) best = cur;
         end else cur = 0;
      end
      return best;
   endfunction

   task automatic run_add(input logic [W-1:0] a, input logic [W-1:0] b, input logic c,
                          input bit full, input bit retrigger);
      int edges;
      int run_len;
      run_len = longest_run(a, b);
      @(negedge clk);
      a_in = a; b_in = b; cin = c; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      edges = 1;
      if (full) begin
         check("R2 busy after start", busy, 1);
         check("R2 done low after start", done, 0);
         check("R2 counter cleared", settle_cycles, 0);
      end
      if (retrigger) begin
         a_in = ~a; b_in = ~b; cin = ~c; start = 1'b1;
         @(negedge clk);
         start = 1'b0;
         edges++;
      end
      while (!done && edges < 40) begin
         @(negedge clk);
         edges++;
      end
      check(retrigger ? "R7 latency unchanged" : "R6 latency", edges - 1, run_len + 2);
      check(retrigger ? "R7 sum unchanged" : "R6 sum", {cout, sum}, a + b + c);
      check("R5 settle cycles", settle_cycles, run_len + 1);
      check("R6 busy low", busy, 0);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R8 busy", busy, 0);
      check("R8 done", done, 0);
      check("R8 sum", {cout, sum}, 0);
      check("R8 cycles", settle_cycles, 0);
      rst_n = 1'b1;

      // R1 R3 R4 R5 R6: full sweep of operands and carry-in
      for (int c = 0; c < 2; c++)
         for (int a = 0; a < (1 << W); a++)
            for (int b = 0; b < (1 << W); b++)
               run_add(W'(a), W'(b), c[0], (a == b), 1'b0);

      // R4: carry-out is the last to settle on an all-propagate chain
      run_add({W{1'b1}}, '0, 1'b1, 1'b1, 1'b0);
      // R7: start during a long chain is ignored
      run_add({W{1'b1}}, '0, 1'b1, 1'b0, 1'b1);

      // R9: results held while idle
      repeat (5) @(negedge clk);
      check("R9 done held", done, 1);
      check("R9 sum held", {cout, sum}, 64);
      @(negedge clk);
      a_in = 6'd3; b_in = 6'd4; cin = 1'b0; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      check("R9 done cleared by start", done, 0);

      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule